// File: doc/BRIEF.md
# Flash Command Interface with Reset and Power-Down

This block is the control front end of a small block-erasable flash model. A host drives chip enable, write enable and output enable with an address and a data word. Each write strobe hands one byte to a command interpreter. A write state machine carries out word programs and block erases, using counters to model how long they take. A status register records how each operation ended. A small internal register array stands in for the cells. Programming can only clear bits, so a programmed word is the old word ANDed with the data. An erase returns a whole block to all ones.

An active-low reset/power-down pin overrides everything else. While it is low the outputs are not driven, any operation in progress is aborted and leaves its target corrupted, the status bits are cleared, and the interpreter falls back to read-array mode. After the pin rises, reads stay undriven for a recovery window. In array mode they also stay undriven until chip enable falls or the address moves. A lockout flag represents a collapsed supply. While it is high, writes are blocked and the interpreter is held in read-array mode. The bus is pin-level rather than a stream: the host issues a command by pulsing the strobes and waits for `ready`, so nothing can push back.

Top module: `flash_cmd_front`

## Requirements
- R1: While `pd_n` is low, `dout_en` is 0 whatever `ce_n`, `oe_n` and `we_n` do, and `ready` is 1.
- R2: Pulling `pd_n` low while a program is running leaves the target word at 0x00. Pulling it low while an erase is running leaves every word of the target block at 0x00. In both cases `ready` returns to 1.
- R3: A low `pd_n` clears status bits 5, 4 and 3 and puts the interpreter in read-array mode.
- R4: After `pd_n` rises, `dout_en` stays 0 until the clock edge that completes RECOV_CYC cycles with `pd_n` high. In read-array mode it also stays 0 until `ce_n` has had a falling edge or `addr` has changed while `pd_n` is high.
- R5: A write is taken once per strobe, in the cycle in which `ce_n` and `we_n` are first both low. A cycle in which either of them is high writes nothing.
- R6: Command 0x40 followed by a data write programs `mem[addr] <= mem[addr] & data`. `ready` is 0 for exactly PROG_CYC cycles, counted from the clock edge that takes the data write.
- R7: Command 0x20 followed by 0xD0 sets all words of one block to 0xFF, with `ready` low for ERASE_CYC cycles. The block is selected by the top BLK_W bits of `addr`, so each block holds 2^(ADDR_W-BLK_W) words.
- R8: Command 0x20 followed by any byte other than 0xD0 leaves the array unchanged, sets status bits 5 and 4, and selects status output.
- R9: Command 0x70 selects status output. Reads return status from a setup command until the next 0xFF is accepted, including after the operation completes. 0xFF selects array output.
- R10: The status byte is {ready, 0, erase/sequence error, program error, no programming voltage, 000}. Bit 4 is set when a program leaves the word different from its data. With `vpp_ok` low at the start of an operation, nothing is changed, `ready` stays 1, and bit 3 is set together with bit 4 (program) or bit 5 (erase). Command 0x50 clears bits 5 to 3 and keeps the output selection.
- R11: Changes on `vpp_ok` or `ce_n` alone do not change the output selection. Writes that arrive while `ready` is 0 are ignored.
- R12: While `vcc_low` is 1, writes are ignored and the interpreter is forced to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pd_n | input | 1 | Active-low reset/power-down; also the reset of all control state |
| vcc_low | input | 1 | Supply below lockout level |
| vpp_ok | input | 1 | Programming voltage present |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Command or program data |
| dout | output | DATA_W | Array word or status byte |
| dout_en | output | 1 | Drive enable for `dout` (0 = high impedance) |
| ready | output | 1 | Write state machine idle |

## Verification
The bench goes after the following corner cases:
- Power-down arriving in the middle of a program or an erase. A design that let the operation finish, or that cleared the wrong block, would read back 0xFF or data instead of 0x00 in the affected words.
- The recovery window, stepped one cycle at a time. A design that counted one cycle short or one cycle long would show `dout_en` a cycle early or a cycle late.
- The arming condition after power-up. Without it, `dout_en` would rise with no falling edge on `ce_n` and no address change.
- Writes with only one strobe low, writes during a busy operation, and writes under lockout. Each must leave the output selection untouched, so a design that accepted any of them would switch between status and array output.
- Sequence errors and missing programming voltage. A design that performed the operation anyway would change array words and leave the wrong status code.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;

  typedef enum logic [1:0] {
    CM_ARRAY,
    CM_STATUS,
    CM_PSETUP,
    CM_ESETUP
  } cui_mode_e;

  typedef enum logic [1:0] {
    WOP_IDLE,
    WOP_PROG,
    WOP_ERASE
  } wsm_op_e;

  typedef struct packed {
    logic erase_err;
    logic prog_err;
    logic vpp_low;
  } sticky_t;
endpackage

// File: rtl/fcf_cmd_ctrl.sv
module fcf_cmd_ctrl
  import fcf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              vcc_low,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wsm_busy,
  output logic              rd_array,
  output logic              start_prog,
  output logic              start_erase,
  output logic              seq_err,
  output logic              clr_status
);
  cui_mode_e   mode_q, mode_d;
  logic        strobe, strobe_q, wr_pulse, wr_ok;
  logic [7:0]  cmd;

  assign strobe   = ~ce_n & ~we_n;
  assign wr_pulse = strobe & ~strobe_q;
  // Writes are dropped while powered down, locked out or busy.
  assign wr_ok    = wr_pulse & pd_n & ~wsm_busy & ~vcc_low;
  assign cmd      = wdata[7:0];
  assign rd_array = (mode_q == CM_ARRAY);

  always_comb begin
    mode_d      = mode_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    seq_err     = 1'b0;
    clr_status  = 1'b0;
    if (vcc_low) begin
      mode_d = CM_ARRAY;
    end else if (wr_ok) begin
      case (mode_q)
        CM_PSETUP: begin
          start_prog = 1'b1;
          mode_d     = CM_STATUS;
        end
        CM_ESETUP: begin
          if (cmd == CMD_ERASE_GO) start_erase = 1'b1;
          else                     seq_err     = 1'b1;
          mode_d = CM_STATUS;
        end
        default: begin
          case (cmd)
            CMD_RD_ARRAY:    mode_d = CM_ARRAY;
            CMD_RD_STATUS:   mode_d = CM_STATUS;
            CMD_CLR_STATUS:  clr_status = 1'b1;
            CMD_PROG_SETUP:  mode_d = CM_PSETUP;
            CMD_ERASE_SETUP: mode_d = CM_ESETUP;
            default:         mode_d = mode_q;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!pd_n) begin
      mode_q   <= CM_ARRAY;
      strobe_q <= strobe;
    end else begin
      mode_q   <= mode_d;
      strobe_q <= strobe;
    end
  end
endmodule

// File: rtl/fcf_wsm.sv
module fcf_wsm
  import fcf_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              vpp_ok,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              seq_err,
  input  logic              clr_status,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] tgt_word,
  output logic              busy,
  output logic [7:0]        status,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              prog_commit,
  output logic              erase_commit,
  output logic              prog_kill,
  output logic              erase_kill
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  wsm_op_e     op_q;
  logic [CW-1:0] cnt_q;
  sticky_t     sticky_q;
  logic        last, prog_fail;

  assign busy         = (op_q != WOP_IDLE);
  assign last         = busy && (cnt_q == CW'(1));
  assign prog_commit  = pd_n && (op_q == WOP_PROG) && last;
  assign erase_commit = pd_n && (op_q == WOP_ERASE) && last;
  assign prog_kill    = !pd_n && (op_q == WOP_PROG);
  assign erase_kill   = !pd_n && (op_q == WOP_ERASE);
  assign prog_fail    = ((tgt_word & tgt_data) != tgt_data);
  assign status       = {~busy, 1'b0, sticky_q.erase_err, sticky_q.prog_err,
                         sticky_q.vpp_low, 3'b000};

  always_ff @(posedge clk) begin
    if (!pd_n) begin
      op_q     <= WOP_IDLE;
      cnt_q    <= '0;
      sticky_q <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      if (clr_status) sticky_q <= '0;
      if (seq_err) begin
        sticky_q.erase_err <= 1'b1;
        sticky_q.prog_err  <= 1'b1;
      end
      if (start_prog) begin
        tgt_addr <= addr;
        tgt_data <= wdata;
        if (vpp_ok) begin
          op_q  <= WOP_PROG;
          cnt_q <= CW'(PROG_CYC);
        end else begin
          sticky_q.vpp_low  <= 1'b1;
          sticky_q.prog_err <= 1'b1;
        end
      end
      if (start_erase) begin
        tgt_addr <= addr;
        tgt_data <= wdata;
        if (vpp_ok) begin
          op_q  <= WOP_ERASE;
          cnt_q <= CW'(ERASE_CYC);
        end else begin
          sticky_q.vpp_low   <= 1'b1;
          sticky_q.erase_err <= 1'b1;
        end
      end
      if (busy) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) op_q <= WOP_IDLE;
        if (prog_commit && prog_fail) sticky_q.prog_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcf_array.sv
module fcf_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              prog_en,
  input  logic              erase_en,
  input  logic              prog_kill,
  input  logic              erase_kill,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] tword
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int SHIFT = ADDR_W - BLK_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [BLK_W-1:0]  wblk;

  function automatic logic [BLK_W-1:0] blk_of(input int idx);
    return BLK_W'(idx >> SHIFT);
  endfunction

  assign wblk  = waddr[ADDR_W-1 -: BLK_W];
  assign rdata = mem[raddr];
  assign tword = mem[waddr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if ((erase_en || erase_kill) && (blk_of(i) == wblk))
        mem[i] <= erase_kill ? '0 : '1;
    end
    if (prog_kill)    mem[waddr] <= '0;
    else if (prog_en) mem[waddr] <= mem[waddr] & wdata;
  end
endmodule

// File: rtl/fcf_pd_gate.sv
module fcf_pd_gate #(
  parameter int ADDR_W    = 6,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_array,
  output logic              out_en
);
  localparam int RW = $clog2(RECOV_CYC + 1) + 1;

  logic [RW-1:0]     rec_cnt;
  logic              armed, ce_q, recovered;
  logic [ADDR_W-1:0] addr_q;

  assign recovered = (rec_cnt == RW'(RECOV_CYC));
  assign out_en    = pd_n & ~ce_n & ~oe_n & recovered & (armed | ~rd_array);

  always_ff @(posedge clk) begin
    if (!pd_n) begin
      rec_cnt <= '0;
      armed   <= 1'b0;
      ce_q    <= ce_n;
      addr_q  <= addr;
    end else begin
      if (!recovered) rec_cnt <= rec_cnt + RW'(1);
      ce_q   <= ce_n;
      addr_q <= addr;
      if ((ce_q && !ce_n) || (addr != addr_q)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import fcf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              pd_n,
  input  logic              vcc_low,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ready
);
  logic              rd_array, start_prog_w, start_erase_w, seq_err_w, clr_w;
  logic              busy_w, pcommit, ecommit, pkill, ekill;
  logic [7:0]        status_w;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data, tgt_word, rdata;

  fcf_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .pd_n(pd_n), .vcc_low(vcc_low), .ce_n(ce_n), .we_n(we_n),
    .wdata(din), .wsm_busy(busy_w), .rd_array(rd_array),
    .start_prog(start_prog_w), .start_erase(start_erase_w),
    .seq_err(seq_err_w), .clr_status(clr_w)
  );

  fcf_wsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC),
            .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk(clk), .pd_n(pd_n), .vpp_ok(vpp_ok), .start_prog(start_prog_w),
    .start_erase(start_erase_w), .seq_err(seq_err_w), .clr_status(clr_w),
    .addr(addr), .wdata(din), .tgt_word(tgt_word), .busy(busy_w),
    .status(status_w), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .prog_commit(pcommit), .erase_commit(ecommit),
    .prog_kill(pkill), .erase_kill(ekill)
  );

  fcf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_arr (
    .clk(clk), .prog_en(pcommit), .erase_en(ecommit), .prog_kill(pkill),
    .erase_kill(ekill), .waddr(tgt_addr), .wdata(tgt_data),
    .raddr(addr), .rdata(rdata), .tword(tgt_word)
  );

  fcf_pd_gate #(.ADDR_W(ADDR_W), .RECOV_CYC(RECOV_CYC)) u_gate (
    .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .rd_array(rd_array), .out_en(dout_en)
  );

  assign dout  = rd_array ? rdata : DATA_W'(status_w);
  assign ready = ~busy_w;
endmodule

// File: rtl/fcf_checker.sv
module fcf_checker (
  input logic       clk,
  input logic       pd_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       vcc_low,
  input logic       vpp_ok,
  input logic       dout_en,
  input logic       ready,
  input logic       rd_array,
  input logic [2:0] sticky_bits,
  input logic       start_prog,
  input logic       start_erase
);
  a_r1_hiz_in_pd: assert property (@(posedge clk) !pd_n |-> !dout_en);

  a_r3_status_cleared: assert property (@(posedge clk)
    !pd_n |=> (sticky_bits == 3'b000));

  a_r4_no_early_drive: assert property (@(posedge clk) !pd_n |=> !dout_en);

  a_r5_no_strobe_no_change: assert property (@(posedge clk) disable iff (!pd_n)
    ((ce_n || we_n) && !vcc_low) |=> $stable(rd_array));

  a_r12_lockout_array: assert property (@(posedge clk) disable iff (!pd_n)
    vcc_low |=> rd_array);

  a_r6_start_drops_ready: assert property (@(posedge clk) disable iff (!pd_n)
    ((start_prog || start_erase) && vpp_ok) |=> !ready);

  a_r10_vpp_missing: assert property (@(posedge clk) disable iff (!pd_n)
    ((start_prog || start_erase) && !vpp_ok) |=> (sticky_bits[0] && ready));
endmodule

bind flash_cmd_front fcf_checker u_chk (
  .clk(clk), .pd_n(pd_n), .ce_n(ce_n), .we_n(we_n), .vcc_low(vcc_low),
  .vpp_ok(vpp_ok), .dout_en(dout_en), .ready(ready), .rd_array(rd_array),
  .sticky_bits(status_w[5:3]), .start_prog(start_prog_w),
  .start_erase(start_erase_w)
);

// File: tb/flash_cmd_front_test.sv
module flash_cmd_front_test;
  localparam int DW = 8, AW = 6, BW = 2, PC = 8, EC = 24, RC = 4;
  localparam int WORDS = 1 << AW;
  localparam int BLK = 1 << (AW - BW);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic pd_n = 1'b0, vcc_low = 1'b0, vpp_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, ready;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [WORDS];

  flash_cmd_front #(.DATA_W(DW), .ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PC),
                    .ERASE_CYC(EC), .RECOV_CYC(RC)) uut (
    .clk(clk), .pd_n(pd_n), .vcc_low(vcc_low), .vpp_ok(vpp_ok), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input bit e, input bit p, input bit v);
    return {1'b1, 1'b0, e, p, v, 3'b000};
  endfunction

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk); oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic busy_count(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); d = dout; en = dout_en;
  endtask

  task automatic power_cycle(input int low_cyc);
    @(negedge clk); pd_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (low_cyc) @(negedge clk);
    pd_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (RC + 1) @(negedge clk);
  endtask

  task automatic sweep(input int lo, input int hi, input string req);
    logic [7:0] d; logic en;
    for (int a = lo; a < hi; a++) begin
      rd(AW'(a), d, en);
      chk(d == model[a] && en, req, int'(d), int'(model[a]));
    end
  endtask

  task automatic expect_status(input logic [7:0] exp, input string req);
    logic [7:0] d; logic en;
    rd('0, d, en);
    chk(d == exp && en, req, int'(d), int'(exp));
  endtask

  initial begin
    logic [7:0] d, pat;
    logic en;
    int n;
    bit fl;

    // R1: power-down holds outputs off
    repeat (3) @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(!dout_en, "R1 hiz in power-down", int'(dout_en), 0);
    chk(ready, "R1 ready in power-down", int'(ready), 1);

    // R4: no arming event -> stays off after recovery
    pd_n = 1'b1;
    for (int k = 1; k <= RC + 3; k++) begin
      @(negedge clk);
      chk(!dout_en, "R4 unarmed stays off", int'(dout_en), 0);
    end
    addr = AW'(1);
    @(negedge clk);
    chk(dout_en, "R4 address change arms", int'(dout_en), 1);

    // R4: recovery window cycle by cycle
    pd_n = 1'b0; ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    pd_n = 1'b1; ce_n = 1'b0;
    for (int k = 1; k <= RC + 2; k++) begin
      @(negedge clk);
      chk(dout_en == (k >= RC), "R4 recovery count", int'(dout_en), int'(k >= RC));
    end

    // R7 and R9: erase every block
    for (int b = 0; b < (1 << BW); b++) begin
      wr(8'h20, AW'(b * BLK));
      wr(8'hD0, AW'(b * BLK));
      if (b == 0) begin
        busy_count(n);
        chk(n == EC, "R7 erase busy length", n, EC);
      end else if (b == 1) begin
        rd('0, d, en);
        chk(d == 8'h00 && en, "R9 status while busy", int'(d), 0);
        busy_count(n);
      end else busy_count(n);
    end
    expect_status(8'h80, "R9 status after erase");
    wr(8'hFF, '0);
    for (int a = 0; a < WORDS; a++) model[a] = 8'hFF;
    sweep(0, WORDS, "R7 erased array");

    // R6: program every word
    for (int a = 0; a < WORDS; a++) begin
      pat = 8'((a * 53 + 17) & 8'hFF);
      model[a] = model[a] & pat;
      wr(8'h40, AW'(a));
      wr(pat, AW'(a));
      busy_count(n);
      chk(n == PC, "R6 program busy length", n, PC);
    end
    wr(8'hFF, '0);
    sweep(0, WORDS, "R6 programmed array");
    wr(8'h70, '0);
    expect_status(8'h80, "R9 read status command");

    // R10: program error and clear
    for (int j = 0; j < 3; j++) begin
      pat = (j == 0) ? 8'hFF : ((j == 1) ? 8'h03 : 8'h00);
      fl = ((model[10] & pat) != pat);
      model[10] = model[10] & pat;
      wr(8'h40, AW'(10));
      wr(pat, AW'(10));
      busy_count(n);
      expect_status(st(1'b0, fl, 1'b0), "R10 program error flag");
      wr(8'h50, '0);
      expect_status(8'h80, "R10 clear status");
    end
    wr(8'hFF, '0);
    sweep(8, 12, "R6 AND semantics");

    // R8: bad erase sequence
    wr(8'h20, AW'(BLK));
    wr(8'h33, AW'(BLK));
    chk(ready, "R8 no operation started", int'(ready), 1);
    expect_status(st(1'b1, 1'b1, 1'b0), "R8 sequence error bits");
    wr(8'hFF, '0);
    sweep(BLK, 2 * BLK, "R8 block untouched");
    wr(8'h50, '0);
    wr(8'h70, '0);
    expect_status(8'h80, "R10 clear from array mode");

    // R10 and R11: missing programming voltage
    vpp_ok = 1'b0;
    wr(8'h40, AW'(20));
    wr(8'h00, AW'(20));
    chk(ready, "R10 program refused", int'(ready), 1);
    expect_status(st(1'b0, 1'b1, 1'b1), "R10 vpp missing program");
    wr(8'h50, '0);
    wr(8'h20, AW'(2 * BLK));
    wr(8'hD0, AW'(2 * BLK));
    expect_status(st(1'b1, 1'b0, 1'b1), "R10 vpp missing erase");
    @(negedge clk); vpp_ok = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    expect_status(st(1'b1, 1'b0, 1'b1), "R11 vpp and ce toggles keep mode");
    wr(8'hFF, '0);
    sweep(20, 21, "R10 word untouched");
    sweep(2 * BLK, 2 * BLK + 2, "R10 block untouched");
    wr(8'h50, '0);

    // R11: writes during busy ignored
    pat = model[40] & 8'h5A;
    model[40] = pat;
    wr(8'h40, AW'(40));
    wr(pat, AW'(40));
    wr(8'hFF, '0);
    busy_count(n);
    expect_status(8'h80, "R11 write while busy ignored");

    // R5: single-strobe writes do nothing
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; din = 8'hFF;
    @(negedge clk); we_n = 1'b1;
    expect_status(8'h80, "R5 we only ignored");
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; din = 8'hFF;
    @(negedge clk); ce_n = 1'b1;
    expect_status(8'h80, "R5 ce only ignored");
    wr(8'hFF, '0);
    sweep(40, 41, "R5 full strobe accepted");

    // R12: lockout
    wr(8'h70, '0);
    expect_status(8'h80, "R12 status before lockout");
    @(negedge clk); vcc_low = 1'b1;
    @(negedge clk);
    sweep(3, 4, "R12 lockout forces array");
    wr(8'h70, '0);
    sweep(3, 4, "R12 write under lockout ignored");
    @(negedge clk); vcc_low = 1'b0;
    wr(8'h70, '0);
    expect_status(8'h80, "R12 writes resume");

    // R2 and R3: abort program
    wr(8'h20, '0);
    wr(8'h11, '0);
    pat = model[9] & 8'hF0;
    wr(8'h40, AW'(9));
    wr(pat, AW'(9));
    repeat (3) @(negedge clk);
    chk(!ready, "R2 program running", int'(ready), 0);
    @(negedge clk); pd_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk(ready && !dout_en, "R2 abort idles", int'({ready, dout_en}), 2);
    pd_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (RC + 1) @(negedge clk);
    model[9] = 8'h00;
    sweep(9, 10, "R2 R3 aborted word in array mode");
    wr(8'h70, '0);
    expect_status(8'h80, "R3 status cleared");

    // R2: abort erase
    wr(8'hFF, '0);
    wr(8'h20, AW'(3 * BLK));
    wr(8'hD0, AW'(3 * BLK));
    repeat (5) @(negedge clk);
    power_cycle(2);
    for (int a = 3 * BLK; a < 4 * BLK; a++) model[a] = 8'h00;
    sweep(0, WORDS, "R2 array after erase abort");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule